// File: doc/BRIEF.md
# Dual Limiter Gain Engine

This block computes gain-reduction values for up to eight audio channels using two shared, independent limiters. Each channel carries a 2-bit assignment code. The code ties the channel to limiter A or limiter B, or leaves it unlimited. On every sample strobe, each limiter takes the loudest level among the channels assigned to it. It compares that level with an attack threshold and a release threshold. The limiter then raises, lowers or keeps its attenuation by a per-sample step taken from 4-bit rate codes.

Levels, the volume reference and thresholds are signed whole decibels. Attenuation is an unsigned fixed-point decibel value with 16 fractional bits, sized for a 192 kHz processing rate. A mode bit chooses the reference point for both limiters. In full-scale mode the thresholds are measured from 0 dB. In compression mode they are measured from the volume input. Converting signal level to dB and applying the gain to the audio are done elsewhere.

Top module: `lim_dual_gain`

## Requirements
- R1: While reset is asserted and after its release, every channel attenuation output is 0.
- R2: Channel k uses assignment code `map_i[2k+1:2k]`, with these meanings:
  - 01 assigns the channel to limiter A.
  - 10 assigns the channel to limiter B.
  - 00 and 11 leave the channel unlimited, and its attenuation output is 0.
- R3: Each limiter is driven by the largest level among its assigned channels. Every channel assigned to a limiter outputs that limiter's attenuation. A limiter with no assigned channels sees the most negative level.
- R4: On a strobe where the limiter level is strictly above the attack threshold, attenuation grows by the attack step. It saturates at 2^ATT_W-1.
- R5: Attack rates by code, in dB/ms:
  - Code 0: 3.1584. Code 1: 2.7072. Code 2: 2.2560. Code 3: 1.8048.
  - Code 4: 1.3536. Code 5: 0.9024. Code 6: 0.4512. Code 7: 0.2256.
  - Code 8: 0.1504. Code 9: 0.1123. Code 10: 0.0902. Code 11: 0.0752.
  - Code 12: 0.0645. Code 13: 0.0564. Code 14: 0.0501. Code 15: 0.0451.
  - The step is round(rate·65536/192).
- R6: On a strobe where attack does not apply and the level is strictly below an enabled release threshold, attenuation shrinks by the release step. It never goes below 0.
- R7: Release rates by code, in dB/ms, with the step computed as in R5:
  - Code 0: 0.5116. Code 1: 0.1370. Code 2: 0.0744. Code 3: 0.0499.
  - Code 4: 0.0360. Code 5: 0.0299. Code 6: 0.0250. Code 7: 0.0210.
  - Code 8: 0.0180. Code 9: 0.0150. Code 10: 0.0120. Code 11: 0.0100.
  - Code 12: 0.0080. Code 13: 0.0060. Code 14: 0.0045. Code 15: 0.0030.
- R8: On a strobe where the level lies between the release threshold and the attack threshold, inclusive of both, attenuation holds.
- R9: Release threshold code 0 stands for minus infinity, so the limiter never releases with that code.
- R10: Thresholds are computed from the codes as follows:
  - The attack threshold is REF − 2·(15 − code) dB.
  - The release threshold is REF − 4·(16 − code) dB.
  - REF is 0 when `drc_mode_i` is 0 (full-scale mode) and the signed `vol_i` when it is 1 (compression mode).
- R11: Without a strobe, no attenuation changes, whatever the levels.
- R12: The field layout is as follows:
  - Limiter A codes sit in bits [3:0] of each code port, and limiter B codes in bits [7:4].
  - Channel k level is `lvl_i[8k+7:8k]`, in two's complement.
  - Channel k attenuation is `att_o[24k+23:24k]`.
  - Attenuation is updated at the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; one limiter update per high cycle |
| lvl_i | input | N_CH*LVL_W | Per-channel peak level, signed dB |
| map_i | input | 2*N_CH | Per-channel limiter assignment codes |
| atk_thr_i | input | 8 | Attack threshold codes, A low nibble, B high nibble |
| rel_thr_i | input | 8 | Release threshold codes, A low nibble, B high nibble |
| atk_rate_i | input | 8 | Attack rate codes, A low nibble, B high nibble |
| rel_rate_i | input | 8 | Release rate codes, A low nibble, B high nibble |
| drc_mode_i | input | 1 | 0: thresholds from full scale; 1: thresholds from volume |
| vol_i | input | LVL_W | Volume reference, signed dB |
| att_o | output | N_CH*ATT_W | Per-channel attenuation, unsigned dB with 16 fractional bits |

## Verification
The bench drives a long run of continuous strobes into one limiter so that attenuation reaches full scale. A design that wraps instead of saturating would fall back to a small value there. A short attack followed by fast releases tests the floor: a design without it would underflow to a huge attenuation. The bench also covers release code 0, where a design treating the code as a real threshold would release. It covers compression mode with a negative volume, which separates a design that ignores the reference from one that honours it. Randomized samples mix the two reserved assignment codes, empty limiters, levels sitting exactly on thresholds and every rate code. These catch off-by-one comparisons, wrong peak selection and swapped nibbles.

// File: rtl/lim_pkg.sv
package lim_pkg;

   localparam int unsigned CODE_W = 4;

   typedef enum logic [1:0] {
      MAP_NONE = 2'b00,
      MAP_A    = 2'b01,
      MAP_B    = 2'b10,
      MAP_RSVD = 2'b11
   } lim_map_e;

   // attack slope per code, in units of 1e-4 dB/ms
   function automatic int unsigned atk_rate_e4(input logic [CODE_W-1:0] c);
      int unsigned r;
      case (c)
         4'd0:    r = 31584;
         4'd1:    r = 27072;
         4'd2:    r = 22560;
         4'd3:    r = 18048;
         4'd4:    r = 13536;
         4'd5:    r = 9024;
         4'd6:    r = 4512;
         4'd7:    r = 2256;
         4'd8:    r = 1504;
         4'd9:    r = 1123;
         4'd10:   r = 902;
         4'd11:   r = 752;
         4'd12:   r = 645;
         4'd13:   r = 564;
         4'd14:   r = 501;
         default: r = 451;
      endcase
      return r;
   endfunction

   // release slope per code, in units of 1e-4 dB/ms
   function automatic int unsigned rel_rate_e4(input logic [CODE_W-1:0] c);
      int unsigned r;
      case (c)
         4'd0:    r = 5116;
         4'd1:    r = 1370;
         4'd2:    r = 744;
         4'd3:    r = 499;
         4'd4:    r = 360;
         4'd5:    r = 299;
         4'd6:    r = 250;
         4'd7:    r = 210;
         4'd8:    r = 180;
         4'd9:    r = 150;
         4'd10:   r = 120;
         4'd11:   r = 100;
         4'd12:   r = 80;
         4'd13:   r = 60;
         4'd14:   r = 45;
         default: r = 30;
      endcase
      return r;
   endfunction

   // dB/ms slope to fixed-point dB per sample, rounded to nearest
   function automatic longint unsigned rate_to_step(input int unsigned r_e4,
                                                    input int unsigned frac,
                                                    input int unsigned khz);
      longint unsigned num;
      longint unsigned den;
      num = longint'(r_e4) << frac;
      den = longint'(khz) * 64'd10000;
      return (num + den / 2) / den;
   endfunction

endpackage

// File: rtl/lim_peak.sv
module lim_peak
   import lim_pkg::*;
#(
   parameter int unsigned N_CH  = 8,
   parameter int unsigned LVL_W = 8,
   parameter lim_map_e    SEL   = MAP_A
) (
   input  logic [N_CH*LVL_W-1:0] lvl_i,
   input  logic [2*N_CH-1:0]     map_i,
   output logic signed [LVL_W-1:0] peak_o
);

   localparam logic signed [LVL_W-1:0] LVL_FLOOR = {1'b1, {(LVL_W-1){1'b0}}};

   always_comb begin
      peak_o = LVL_FLOOR;
      for (int k = 0; k < N_CH; k++) begin
         if ((map_i[2*k +: 2] == SEL) &&
             ($signed(lvl_i[k*LVL_W +: LVL_W]) > peak_o))
            peak_o = $signed(lvl_i[k*LVL_W +: LVL_W]);
      end
   end

endmodule

// File: rtl/lim_core.sv
module lim_core
   import lim_pkg::*;
#(
   parameter int unsigned LVL_W      = 8,
   parameter int unsigned ATT_W      = 24,
   parameter int unsigned ATT_FRAC   = 16,
   parameter int unsigned SAMPLE_KHZ = 192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stb,
   input  logic signed [LVL_W-1:0] peak_i,
   input  logic signed [LVL_W-1:0] ref_i,
   input  logic [CODE_W-1:0]       atk_code,
   input  logic [CODE_W-1:0]       rel_code,
   input  logic [CODE_W-1:0]       atk_rate,
   input  logic [CODE_W-1:0]       rel_rate,
   output logic [ATT_W-1:0]        att_o
);

   localparam int unsigned THR_W = LVL_W + 2;

   logic signed [THR_W-1:0] pk_x, ref_x, atk_thr, rel_thr;
   logic [ATT_W-1:0]        atk_step, rel_step, up_sat, dn_flr, att_q;
   logic [ATT_W:0]          up_sum;
   logic                    go_atk, go_rel;
   int                      a_off, r_off;

   assign pk_x  = {{2{peak_i[LVL_W-1]}}, peak_i};
   assign ref_x = {{2{ref_i[LVL_W-1]}}, ref_i};

   always_comb begin
      a_off   = 2 * (15 - int'(atk_code));
      r_off   = 4 * (16 - int'(rel_code));
      atk_thr = ref_x - THR_W'(a_off);
      rel_thr = ref_x - THR_W'(r_off);
   end

   assign go_atk = pk_x > atk_thr;
   assign go_rel = (rel_code != '0) && (pk_x < rel_thr);

   assign atk_step = ATT_W'(rate_to_step(atk_rate_e4(atk_rate), ATT_FRAC, SAMPLE_KHZ));
   assign rel_step = ATT_W'(rate_to_step(rel_rate_e4(rel_rate), ATT_FRAC, SAMPLE_KHZ));

   assign up_sum = {1'b0, att_q} + {1'b0, atk_step};
   assign up_sat = up_sum[ATT_W] ? '1 : up_sum[ATT_W-1:0];
   assign dn_flr = (att_q > rel_step) ? (att_q - rel_step) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         att_q <= '0;
      else if (stb) begin
         if (go_atk)
            att_q <= up_sat;
         else if (go_rel)
            att_q <= dn_flr;
      end
   end

   assign att_o = att_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !stb |=> $stable(att_q)); // R11
   AST_ATK_RISE:  assert property (@(posedge clk) disable iff (!rst_n) (stb && go_atk) |=> att_q >= $past(att_q)); // R4
   AST_REL_FALL:  assert property (@(posedge clk) disable iff (!rst_n) (stb && !go_atk && go_rel) |=> att_q <= $past(att_q)); // R6
   AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (stb && !go_atk && !go_rel) |=> $stable(att_q)); // R8
   AST_REL_OFF:   assert property (@(posedge clk) disable iff (!rst_n) (stb && rel_code == '0) |=> att_q >= $past(att_q)); // R9

endmodule

// File: rtl/lim_dual_gain.sv
module lim_dual_gain
   import lim_pkg::*;
#(
   parameter int unsigned N_CH       = 8,
   parameter int unsigned LVL_W      = 8,
   parameter int unsigned ATT_W      = 24,
   parameter int unsigned ATT_FRAC   = 16,
   parameter int unsigned SAMPLE_KHZ = 192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_stb,
   input  logic [N_CH*LVL_W-1:0]   lvl_i,
   input  logic [2*N_CH-1:0]       map_i,
   input  logic [2*CODE_W-1:0]     atk_thr_i,
   input  logic [2*CODE_W-1:0]     rel_thr_i,
   input  logic [2*CODE_W-1:0]     atk_rate_i,
   input  logic [2*CODE_W-1:0]     rel_rate_i,
   input  logic                    drc_mode_i,
   input  logic [LVL_W-1:0]        vol_i,
   output logic [N_CH*ATT_W-1:0]   att_o
);

   localparam int unsigned N_LIM = 2;

   if (ATT_W <= ATT_FRAC) begin : g_bad_frac
      $error("ATT_W must exceed ATT_FRAC");
   end
   if (LVL_W < 7) begin : g_bad_lvl
      $error("LVL_W too narrow for the threshold span");
   end
   if (N_CH < 1) begin : g_bad_nch
      $error("N_CH must be at least 1");
   end

   logic signed [LVL_W-1:0] ref_lvl;
   logic [ATT_W-1:0]        lim_att [N_LIM];

   assign ref_lvl = drc_mode_i ? $signed(vol_i) : '0;

   for (genvar l = 0; l < N_LIM; l++) begin : g_lim
      localparam lim_map_e SEL = (l == 0) ? MAP_A : MAP_B;
      logic signed [LVL_W-1:0] peak;

      lim_peak #(.N_CH(N_CH), .LVL_W(LVL_W), .SEL(SEL)) u_peak (
         .lvl_i  (lvl_i),
         .map_i  (map_i),
         .peak_o (peak)
      );

      lim_core #(.LVL_W(LVL_W), .ATT_W(ATT_W), .ATT_FRAC(ATT_FRAC),
                 .SAMPLE_KHZ(SAMPLE_KHZ)) u_core (
         .clk      (clk),
         .rst_n    (rst_n),
         .stb      (smp_stb),
         .peak_i   (peak),
         .ref_i    (ref_lvl),
         .atk_code (atk_thr_i [l*CODE_W +: CODE_W]),
         .rel_code (rel_thr_i [l*CODE_W +: CODE_W]),
         .atk_rate (atk_rate_i[l*CODE_W +: CODE_W]),
         .rel_rate (rel_rate_i[l*CODE_W +: CODE_W]),
         .att_o    (lim_att[l])
      );
   end

   for (genvar k = 0; k < N_CH; k++) begin : g_route
      logic [ATT_W-1:0] sel;
      always_comb begin
         case (map_i[2*k +: 2])
            MAP_A:   sel = lim_att[0];
            MAP_B:   sel = lim_att[1];
            default: sel = '0;
         endcase
      end
      assign att_o[k*ATT_W +: ATT_W] = sel;
   end

endmodule

// File: tb/tb_lim_dual_gain.sv
`timescale 1ns/1ps
module tb_lim_dual_gain;
   localparam int N_CH  = 8;
   localparam int LVL_W = 8;
   localparam int ATT_W = 24;
   localparam longint ATT_MAX = (64'd1 << ATT_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0, drc_mode = 1'b0;
   logic [N_CH*LVL_W-1:0] lvl = '0;
   logic [2*N_CH-1:0]     map = '0;
   logic [7:0] atk_thr = '0, rel_thr = '0, atk_rate = '0, rel_rate = '0;
   logic [LVL_W-1:0]      vol = '0;
   logic [N_CH*ATT_W-1:0] att;

   int n_chk = 0, n_bad = 0;
   longint m_att [2];
   real atk_tab [16] = '{3.1584, 2.7072, 2.2560, 1.8048, 1.3536, 0.9024, 0.4512, 0.2256,
                         0.1504, 0.1123, 0.0902, 0.0752, 0.0645, 0.0564, 0.0501, 0.0451};
   real rel_tab [16] = '{0.5116, 0.1370, 0.0744, 0.0499, 0.0360, 0.0299, 0.0250, 0.0210,
                         0.0180, 0.0150, 0.0120, 0.0100, 0.0080, 0.0060, 0.0045, 0.0030};

   always #2 clk = ~clk;

   lim_dual_gain dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .lvl_i(lvl), .map_i(map),
      .atk_thr_i(atk_thr), .rel_thr_i(rel_thr), .atk_rate_i(atk_rate), .rel_rate_i(rel_rate),
      .drc_mode_i(drc_mode), .vol_i(vol), .att_o(att)
   );

   function automatic longint stepv(real r);
      return longint'($rtoi(r * 65536.0 / 192.0 + 0.5));
   endfunction

   function automatic void model_step();
      for (int l = 0; l < 2; l++) begin
         int pk, rf, ac, rc, at, rt;
         pk = -128;
         for (int k = 0; k < N_CH; k++)
            if (int'(map[2*k +: 2]) == l + 1 && int'($signed(lvl[k*LVL_W +: LVL_W])) > pk)
               pk = int'($signed(lvl[k*LVL_W +: LVL_W]));
         rf = drc_mode ? int'($signed(vol)) : 0;
         ac = int'(atk_thr[4*l +: 4]);
         rc = int'(rel_thr[4*l +: 4]);
         at = rf - 2 * (15 - ac);
         rt = rf - 4 * (16 - rc);
         if (pk > at) begin
            m_att[l] += stepv(atk_tab[atk_rate[4*l +: 4]]);
            if (m_att[l] > ATT_MAX) m_att[l] = ATT_MAX;
         end else if (rc != 0 && pk < rt) begin
            m_att[l] -= stepv(rel_tab[rel_rate[4*l +: 4]]);
            if (m_att[l] < 0) m_att[l] = 0;
         end
      end
   endfunction

   task automatic check_val(string tag, longint got, longint exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic check_all(string tag);
      for (int k = 0; k < N_CH; k++) begin
         int code;
         longint exp, got;
         code = int'(map[2*k +: 2]);
         exp  = (code == 1) ? m_att[0] : (code == 2) ? m_att[1] : 0;
         got  = longint'(att[k*ATT_W +: ATT_W]);
         n_chk++;
         if (got != exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: got %0d expected %0d", tag, k, got, exp);
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      smp_stb = 1'b0;
      m_att[0] = 0;
      m_att[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic one_sample(string tag);
      @(negedge clk);
      smp_stb = 1'b1;
      model_step();
      @(negedge clk);
      smp_stb = 1'b0;
      check_all(tag);
   endtask

   task automatic set_lvl(int ch, int v);
      lvl[ch*LVL_W +: LVL_W] = LVL_W'(v);
   endtask

   task automatic set_map(int ch, int c);
      map[2*ch +: 2] = 2'(c);
   endtask

   initial begin : wd
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_att[0] = 0;
      m_att[1] = 0;
      // R1: outputs during and after reset
      map = '1;
      set_map(0, 1); set_map(1, 2);
      repeat (2) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");

      // R11: loud levels without strobe change nothing
      map = '0;
      set_map(0, 1); set_map(3, 2);
      for (int k = 0; k < N_CH; k++) set_lvl(k, 100);
      atk_thr = 8'hFF; rel_thr = 8'h00; atk_rate = 8'h00; rel_rate = 8'h00;
      repeat (5) @(negedge clk);
      check_all("R11 no strobe");

      // R4/R5: single attack, fastest code gives 1078
      one_sample("R4 attack");
      check_val("R5 attack step code0", longint'(att[0 +: ATT_W]), 1078);
      check_val("R2 unmapped ch1", longint'(att[ATT_W +: ATT_W]), 0);

      // R9: release threshold code 0 never releases
      for (int k = 0; k < N_CH; k++) set_lvl(k, -120);
      repeat (3) one_sample("R9 release off");
      check_val("R9 still held", longint'(att[0 +: ATT_W]), 1078);

      // R6/R7: fast release down to the floor (1078 - 7*175 -> 0)
      rel_thr = 8'hFF; rel_rate = 8'h00;
      for (int i = 0; i < 7; i++) one_sample("R6 release floor");
      check_val("R6 floor at zero", longint'(att[0 +: ATT_W]), 0);

      // R8: level between thresholds holds
      do_reset();
      set_lvl(0, 10);
      one_sample("R8 prime");
      set_lvl(0, -4); set_lvl(3, 0);   // -4 == release thr, 0 == attack thr
      repeat (3) one_sample("R8 band hold");
      check_val("R8 held value", longint'(att[0 +: ATT_W]), 1078);

      // R10: compression mode with negative volume
      do_reset();
      for (int k = 0; k < N_CH; k++) set_lvl(k, -15);
      rel_thr = 8'hFF;
      drc_mode = 1'b0;
      one_sample("R10 full-scale ref");
      check_val("R10 no attack at -15 in full-scale", longint'(att[0 +: ATT_W]), 0);
      drc_mode = 1'b1;
      vol = LVL_W'(-20);
      one_sample("R10 volume ref");
      check_val("R10 attack at -15 over -20 ref", longint'(att[0 +: ATT_W]), 1078);
      drc_mode = 1'b0;

      // R3/R2/R12: shared peak, reserved code, nibble placement
      do_reset();
      map = '0;
      set_map(0, 1); set_map(1, 1); set_map(2, 3); set_map(5, 2); set_map(6, 2);
      for (int k = 0; k < N_CH; k++) set_lvl(k, -60);
      set_lvl(0, -30); set_lvl(1, 5);   // limiter A peak 5
      set_lvl(2, 120);                  // reserved code, ignored
      set_lvl(7, 120);                  // unmapped, ignored
      atk_thr = 8'hEF;                  // A thr 0, B thr -2
      atk_rate = 8'h70;                 // A code 0, B code 7
      rel_thr = 8'h00;
      one_sample("R3 shared peak");
      check_val("R3 ch1 follows A", longint'(att[ATT_W +: ATT_W]), 1078);
      check_val("R12 B idle", longint'(att[5*ATT_W +: ATT_W]), 0);
      set_lvl(6, 1);
      one_sample("R12 B attack code7");
      check_val("R12 B step 77", longint'(att[6*ATT_W +: ATT_W]), 77);

      // R4 saturation: continuous strobes
      do_reset();
      map = '0;
      set_map(0, 1);
      set_lvl(0, 100);
      atk_thr = 8'hFF; atk_rate = 8'h00; rel_thr = 8'h00;
      @(negedge clk);
      smp_stb = 1'b1;
      repeat (16000) @(posedge clk);
      for (int i = 0; i < 16000; i++) model_step();
      @(negedge clk);
      smp_stb = 1'b0;
      check_all("R4 saturation");
      check_val("R4 saturated max", longint'(att[0 +: ATT_W]), ATT_MAX);

      // Random mix: R2 R3 R4 R5 R6 R7 R8 R10 R12
      do_reset();
      for (int s = 0; s < 500; s++) begin
         map = 16'($urandom);
         for (int k = 0; k < N_CH; k++) set_lvl(k, int'($urandom_range(90, 0)) - 70);
         if (s % 8 == 0) begin
            atk_thr = 8'($urandom); rel_thr = 8'($urandom);
            atk_rate = 8'($urandom); rel_rate = 8'($urandom);
            drc_mode = 1'($urandom);
            vol = LVL_W'(int'($urandom_range(30, 0)) - 20);
         end
         one_sample("R12 random R2 R3 R4 R5 R6 R7 R8 R10");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule